// File: doc/BRIEF.md
# Duplex-Pair Result Switching Decider

This block chooses one trustworthy result per computation step from four redundant processing channels arranged as two self-checking pairs. Each pair compares its own two results. One pair is the acting pair and delivers the output. The other pair runs in parallel as a hot spare. When the acting pair disagrees with itself and the spare agrees, the spare's result goes out and the spare becomes the acting pair. When both pairs disagree, the step is flagged as a detected failure and no result is delivered.

Each pair keeps a count of its consecutive disagreements. After a set number of them, the pair is treated as having a persistent fault and is retired for good. The surviving pair carries on alone and still checks itself. A reduced three-channel arrangement is also supported. In it the middle channel takes part in both comparisons. A double disagreement whose two outer channels match is blamed on that middle channel, and the outer value is delivered.

A step is decided only once every channel still in service has presented a valid result. The decision appears on the outputs one clock later.

Top module: `duplex_switch_decider`

## Requirements
- R1: After reset, out_vld=0, fail_det=0, pair_act=0 (pair 0 acting) and pair_ret=2'b00.
- R2: A step is decided only when every channel needed by a non-retired pair has its bit set in ch_vld. Bit i belongs to channel i. In three-channel mode channel 3 is never needed. The outputs of a step appear one clock after the inputs. On a cycle with no step, out_vld=0 and fail_det is 0 unless both pairs are retired.
- R3: In four-channel mode, pair 0 is channels 0/1 and delivers ch0_data, and pair 1 is channels 2/3 and delivers ch2_data. When the acting pair agrees, its result is delivered with out_vld=1, whether the spare agrees or not.
- R4: When the acting pair disagrees and the other live pair agrees, the other pair's result is delivered with out_vld=1 and fail_det=0, and pair_act switches to that pair.
- R5: When no live pair agrees in a step, the step gives out_vld=0 and fail_det=1. out_vld and fail_det are never high together.
- R6: A disagreeing step increments the counter of a live pair, and an agreeing step clears it. When the counter reaches RETIRE_N (default 3), the pair's pair_ret bit is set and stays set until reset. pair_act always names a live pair while one exists.
- R7: With one pair retired, the survivor compares its two channels and either delivers its result or flags fail_det=1. The retired pair's data and valid inputs have no effect.
- R8: When three_ch=1, pair 0 is channels 0/1 and delivers ch0_data, and pair 1 is channels 1/2 and delivers ch2_data. If both comparisons disagree but ch0_data equals ch2_data, ch0_data is delivered with out_vld=1 and fail_det=0, and no counter changes. If all three channels differ, R5 applies. three_ch may change only during reset.
- R9: Once both pairs are retired, no step is decided: out_vld stays 0 and fail_det stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| three_ch | input | 1 | Selects the three-channel arrangement with a shared middle channel |
| ch_vld | input | 4 | Per-channel result-valid strobes |
| ch0_data | input | W | Result of channel 0 |
| ch1_data | input | W | Result of channel 1 |
| ch2_data | input | W | Result of channel 2 |
| ch3_data | input | W | Result of channel 3 |
| out_data | output | W | Delivered result |
| out_vld | output | 1 | Delivered result is valid for this step |
| fail_det | output | 1 | Detected failure: no trustworthy result |
| pair_act | output | 1 | Index of the acting pair |
| pair_ret | output | 2 | Retired flag per pair |

## Verification
On every cycle, the assertions check the following:
- a valid output and a failure flag are never raised together;
- a delivered word always equals one of the channel words of the previous cycle;
- a retired flag never drops;
- the acting pair is always a live one;
- a fully retired block stays in failure.

Which pair is chosen, when the switch-over happens, how many consecutive mismatches lead to retirement, counter clearing on agreement, and the blame placed on the shared channel all depend on input history. These are shown by the bench's directed scenarios and by random steps compared against the bench's own model.

// File: rtl/duplex_switch_decider.sv
module duplex_switch_decider #(
  parameter int W        = 16,
  parameter int RETIRE_N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         three_ch,
  input  logic [3:0]   ch_vld,
  input  logic [W-1:0] ch0_data,
  input  logic [W-1:0] ch1_data,
  input  logic [W-1:0] ch2_data,
  input  logic [W-1:0] ch3_data,
  output logic [W-1:0] out_data,
  output logic         out_vld,
  output logic         fail_det,
  output logic         pair_act,
  output logic [1:0]   pair_ret
);
  localparam int CW = $clog2(RETIRE_N + 1);
  localparam logic [CW-1:0] LAST = CW'(RETIRE_N - 1);

  logic [CW-1:0] cnt_q [2];
  logic [1:0]    ret_q, ret_n, alive, ok, mm;
  logic [3:0]    need;
  logic          act_q, act_n, fail_q, go, eq0, eq1, shared;
  logic          sel_vld;
  logic [W-1:0]  sel_data;
  logic [W-1:0]  pres [2];

  assign alive   = ~ret_q;
  assign eq0     = ch0_data == ch1_data;
  assign eq1     = three_ch ? (ch1_data == ch2_data) : (ch2_data == ch3_data);
  assign pres[0] = ch0_data;
  assign pres[1] = ch2_data;
  assign ok      = alive & {eq1, eq0};
  assign mm      = alive & ~{eq1, eq0};
  assign need    = {alive[1] & ~three_ch, alive[1],
                    alive[0] | (three_ch & alive[1]), alive[0]};
  assign go      = (|alive) && ((ch_vld & need) == need);
  assign shared  = three_ch && (&alive) && !eq0 && !eq1 && (ch0_data == ch2_data);

  always_comb begin
    sel_vld  = 1'b0;
    sel_data = pres[act_q];
    if (shared) begin
      sel_vld  = 1'b1;
      sel_data = ch0_data;
    end else if (ok[act_q]) begin
      sel_vld  = 1'b1;
    end else if (ok[~act_q]) begin
      sel_vld  = 1'b1;
      sel_data = pres[~act_q];
    end
  end

  always_comb begin
    for (int i = 0; i < 2; i++)
      ret_n[i] = ret_q[i] | (go & ~shared & mm[i] & (cnt_q[i] == LAST));
    act_n = act_q;
    if (go && !shared && !ok[act_q] && ok[~act_q]) act_n = ~act_q;
    if (ret_n[act_n] && !ret_n[~act_n]) act_n = ~act_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_q    <= '0;
      act_q    <= 1'b0;
      out_vld  <= 1'b0;
      fail_q   <= 1'b0;
      out_data <= '0;
      for (int i = 0; i < 2; i++) cnt_q[i] <= '0;
    end else begin
      ret_q   <= ret_n;
      act_q   <= act_n;
      out_vld <= go & sel_vld;
      fail_q  <= go & ~sel_vld;
      if (go) out_data <= sel_data;
      for (int i = 0; i < 2; i++)
        if (go && !shared && alive[i])
          cnt_q[i] <= mm[i] ? ((cnt_q[i] == LAST) ? cnt_q[i] : cnt_q[i] + 1'b1) : '0;
    end
  end

  assign fail_det = fail_q | (&ret_q);
  assign pair_act = act_q;
  assign pair_ret = ret_q;
endmodule

// File: rtl/duplex_switch_decider_chk.sv
module duplex_switch_decider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   ch_vld,
  input logic [W-1:0] ch0_data,
  input logic [W-1:0] ch1_data,
  input logic [W-1:0] ch2_data,
  input logic [W-1:0] ch3_data,
  input logic [W-1:0] out_data,
  input logic         out_vld,
  input logic         fail_det,
  input logic         pair_act,
  input logic [1:0]   pair_ret
);
  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vld && fail_det));
  a_r3_from_channel: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_data == $past(ch0_data) || out_data == $past(ch1_data) ||
                 out_data == $past(ch2_data) || out_data == $past(ch3_data)));
  a_r6_ret0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ret[0] |=> pair_ret[0]);
  a_r6_ret1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ret[1] |=> pair_ret[1]);
  a_r6_act_alive: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_ret != 2'b11) |-> !pair_ret[pair_act]);
  a_r2_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(ch_vld != 4'b0000));
  a_r9_dead: assert property (@(posedge clk) disable iff (!rst_n)
    (&pair_ret) |-> (fail_det && !out_vld));
endmodule

bind duplex_switch_decider duplex_switch_decider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_vld(ch_vld),
  .ch0_data(ch0_data), .ch1_data(ch1_data), .ch2_data(ch2_data), .ch3_data(ch3_data),
  .out_data(out_data), .out_vld(out_vld), .fail_det(fail_det),
  .pair_act(pair_act), .pair_ret(pair_ret));

// File: tb/duplex_switch_decider_bench.sv
module duplex_switch_decider_bench;
  localparam int W = 16;
  localparam int RN = 3;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, three_ch = 1'b0;
  logic [3:0] ch_vld = '0;
  logic [W-1:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0;
  logic [W-1:0] out_data;
  logic out_vld, fail_det, pair_act;
  logic [1:0] pair_ret;

  int errors = 0, checks = 0;
  int m_cnt [2];
  logic [1:0] m_ret;
  logic m_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  duplex_switch_decider #(.W(W), .RETIRE_N(RN)) u_duplex_switch_decider (
    .clk(clk), .rst_n(rst_n), .three_ch(three_ch), .ch_vld(ch_vld),
    .ch0_data(c0), .ch1_data(c1), .ch2_data(c2), .ch3_data(c3),
    .out_data(out_data), .out_vld(out_vld), .fail_det(fail_det),
    .pair_act(pair_act), .pair_ret(pair_ret));

  task automatic check(input string tag, input logic ev, input logic ef,
                       input logic [W-1:0] ed, input logic ea, input logic [1:0] er);
    checks++;
    if (out_vld !== ev || fail_det !== ef || (ev && out_data !== ed) ||
        pair_act !== ea || pair_ret !== er) begin
      errors++;
      $display("FAIL %s: vld=%0b fail=%0b data=%0h act=%0b ret=%0b expected vld=%0b fail=%0b data=%0h act=%0b ret=%0b",
               tag, out_vld, fail_det, out_data, pair_act, pair_ret, ev, ef, ed, ea, er);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; three_ch = mode; ch_vld = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_ret = '0; m_act = 1'b0; m_cnt[0] = 0; m_cnt[1] = 0;
    @(negedge clk);
    check("R1 reset", 1'b0, 1'b0, '0, 1'b0, 2'b00);
  endtask

  // Drives one step right after a negedge and checks the next negedge.
  task automatic step(input string tag, input logic [W-1:0] d0, input logic [W-1:0] d1,
                      input logic [W-1:0] d2, input logic [W-1:0] d3, input logic [3:0] v);
    logic [1:0] live, good, bad;
    logic [3:0] nd;
    logic go, sh, ev, ef, na;
    logic [W-1:0] ed;
    logic [W-1:0] pr [2];
    c0 = d0; c1 = d1; c2 = d2; c3 = d3; ch_vld = v;
    live = ~m_ret;
    good[0] = live[0] && (d0 == d1);
    good[1] = live[1] && (three_ch ? (d1 == d2) : (d2 == d3));
    bad = live & ~good;
    pr[0] = d0; pr[1] = d2;
    nd = three_ch ? {1'b0, live[1], |live, live[0]} : {live[1], live[1], live[0], live[0]};
    go = (|live) && ((v & nd) == nd);
    sh = three_ch && (&live) && bad[0] && bad[1] && (d0 == d2);
    ev = 1'b0; ef = 1'b0; ed = '0; na = m_act;
    if (go) begin
      if (sh) begin ev = 1'b1; ed = d0; end
      else if (good[m_act]) begin ev = 1'b1; ed = pr[m_act]; end
      else if (good[~m_act]) begin ev = 1'b1; ed = pr[~m_act]; na = ~m_act; end
      else ef = 1'b1;
      if (!sh)
        for (int i = 0; i < 2; i++)
          if (live[i]) begin
            if (bad[i]) m_cnt[i]++; else m_cnt[i] = 0;
            if (m_cnt[i] >= RN) m_ret[i] = 1'b1;
          end
      if (m_ret[na] && !m_ret[~na]) na = ~na;
      m_act = na;
    end
    if (&m_ret) ef = 1'b1;
    @(negedge clk);
    check(tag, ev, ef, ed, m_act, m_ret);
  endtask

  function automatic logic [W-1:0] mut(input logic [W-1:0] b, input int pct);
    if (($urandom % 100) < pct) return b ^ W'(($urandom % 255) + 1);
    return b;
  endfunction

  task automatic rand_run(input logic mode, input int n);
    do_reset(mode);
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] b;
      logic [3:0] v;
      b = W'($urandom);
      v = (($urandom % 5) == 0) ? 4'($urandom) : 4'hF;
      if (&m_ret) do_reset(mode);
      step(mode ? "R8 random" : "R3 random", mut(b, 12), mut(b, 12), mut(b, 12),
           mode ? W'($urandom) : mut(b, 12), v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(1'b0);
    step("R3 all agree",            16'h0005, 16'h0005, 16'h0005, 16'h0005, 4'hF);
    step("R3 spare mismatch",       16'h0011, 16'h0011, 16'h0022, 16'h0023, 4'hF);
    step("R2 missing valid",        16'h0011, 16'h0011, 16'h0011, 16'h0011, 4'h7);
    step("R4 switch to spare",      16'h0031, 16'h0032, 16'h0040, 16'h0040, 4'hF);
    step("R5 both mismatch",        16'h0001, 16'h0002, 16'h0003, 16'h0004, 4'hF);
    step("R6 retire pair 0",        16'h0001, 16'h0002, 16'h0050, 16'h0050, 4'hF);
    step("R7 survivor ignores dead",16'hAAAA, 16'h5555, 16'h0060, 16'h0060, 4'hC);
    step("R7 survivor mismatch",    16'h0000, 16'h0000, 16'h0070, 16'h0071, 4'hC);
    step("R7 survivor mismatch 2",  16'h0000, 16'h0000, 16'h0070, 16'h0072, 4'hC);
    step("R9 both retired",         16'h0000, 16'h0000, 16'h0070, 16'h0073, 4'hC);
    step("R9 stays failed",         16'h0009, 16'h0009, 16'h0009, 16'h0009, 4'hF);
    do_reset(1'b0);
    step("R6 count 1",              16'h0001, 16'h0002, 16'h0007, 16'h0007, 4'hF);
    step("R6 clear",                16'h0003, 16'h0003, 16'h0003, 16'h0003, 4'hF);
    step("R6 count again",          16'h0003, 16'h0003, 16'h0001, 16'h0002, 4'hF);
    step("R6 count again 2",        16'h0003, 16'h0003, 16'h0001, 16'h0004, 4'hF);
    step("R6 no retire",            16'h0008, 16'h0008, 16'h0008, 16'h0008, 4'hF);
    do_reset(1'b1);
    step("R8 all agree ch3 ignored",16'h0012, 16'h0012, 16'h0012, 16'hFFFF, 4'h7);
    step("R8 pair 1 mismatch",      16'h0013, 16'h0013, 16'h0099, 16'h0000, 4'h7);
    step("R8 shared channel blamed",16'h0007, 16'h0009, 16'h0007, 16'h0000, 4'h7);
    step("R8 all three differ",     16'h0001, 16'h0002, 16'h0003, 16'h0000, 4'h7);
    step("R2 three_ch needs ch1",   16'h0004, 16'h0004, 16'h0004, 16'h0000, 4'h5);
    rand_run(1'b0, 800);
    rand_run(1'b1, 800);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule